// File: doc/BRIEF.md
# Call/Return Hardware Shift Stack

This block is the return-address and scratch stack of a small processor core. It stores eight 32-bit words in one shift register with no stack pointer. The core's call, return, push and pop strobes move every stored word one place together. A call saves the carry and zero flags and the address of the following instruction in one word. The same cycle, the block works out the branch target. The target is either absolute or relative to the current program counter. A return hands back the saved address and flags from the top word and then pops.

Push and pop carry any 32-bit value, and they use the same storage as call and return. The stack has no address and no pointer, so it cannot be full or empty in a way the core can see:
- Pushing into a full stack silently loses the oldest word.
- Popping never runs out. The bottom word copies upward instead, so repeated pops keep returning the oldest surviving value.

Top module: `call_stack_top`

## Requirements
- R1: While rst_ni is low, every entry is cleared to zero. After release, `tos_o` reads 0, and popping the stack any number of times keeps returning 0 until something is pushed.
- R2: A push (`push_i`) moves every entry down one place and writes `push_data_i` into the top entry. In the next cycle `tos_o` equals the pushed word.
- R3: Overflow is silent. After nine or more pushes, successive pops return the last eight pushed words, newest first, and the oldest word is lost.
- R4: A pop (`pop_i`) moves the upper seven entries up one place, and the bottom entry keeps its value. After eight pops, every further pop returns that same bottom value.
- R5: A call (`call_i`) pushes one word with this layout: bit 31 is `c_i`, bit 30 is `z_i`, bits 29:20 are zero, and bits 19:0 are `pc_i`+1 modulo 2^20.
- R6: During a call, `pc_load_o` is 1. When `rel_i`=1, `pc_next_o` is `pc_i`+`target_i` modulo 2^20. When `rel_i`=0, `pc_next_o` is `target_i`.
- R7: During a return (`ret_i`):
  - `pc_load_o` and `flag_load_o` are 1.
  - `pc_next_o` equals bits 19:0 of the top entry.
  - `c_o` equals bit 31 of the top entry, and `z_o` equals bit 30.
  - The stack then pops as in R4.
- R8: When several strobes are high together, only one operation takes place. The priority order is call, then return, then push, then pop.
- R9: With no strobe high, the stack keeps its contents. In that cycle `pc_next_o` is `pc_i`+1 modulo 2^20, and both `pc_load_o` and `flag_load_o` are 0.
- R10: `tos_o` always shows the current top entry, with no extra cycle of delay after the clock edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| push_data_i | input | 32 | Word written by a push |
| pc_i | input | 20 | Current program counter |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| target_i | input | 20 | Call operand |
| rel_i | input | 1 | 1: relative call target, 0: absolute |
| tos_o | output | 32 | Current top-of-stack word |
| pc_next_o | output | 20 | Next program counter |
| pc_load_o | output | 1 | pc_next_o is a branch target (call or return) |
| c_o | output | 1 | Carry restored from the top entry |
| z_o | output | 1 | Zero restored from the top entry |
| flag_load_o | output | 1 | c_o and z_o are to be loaded (return) |

## Verification
The shift behaviour is tested with several input patterns, and each pattern separates one failure from the others:
- Popping a freshly reset stack, and pushing nine distinct words then popping ten, separates a correct shift from a pointer that wraps around, a bottom entry that is not held, and an oldest word that is not discarded.
- Calls are made with both addressing modes, with operands that wrap past 2^20, and with a program counter at its maximum. These show whether the saved address and the target are correct, and whether the flag bits are placed correctly in the saved word.
- Strobes are raised in combination to pin down the priority order.
- A long run of random operations compares every output against a model built on a queue.

// File: rtl/call_stack_pkg.sv
package call_stack_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CALL,
    OP_RET,
    OP_PUSH,
    OP_POP
  } stk_op_e;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_DOWN,
    SH_UP
  } shift_e;

endpackage

// File: rtl/cs_op_arbiter.sv
module cs_op_arbiter
  import call_stack_pkg::*;
(
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);

  // fixed priority: call > ret > push > pop
  always_comb begin
    if (call_i)      op_o = OP_CALL;
    else if (ret_i)  op_o = OP_RET;
    else if (push_i) op_o = OP_PUSH;
    else if (pop_i)  op_o = OP_POP;
    else             op_o = OP_IDLE;
  end

endmodule

// File: rtl/cs_flow_unit.sv
module cs_flow_unit
  import call_stack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 20
) (
  input  stk_op_e             op_i,
  input  logic [WORD_W-1:0]   push_data_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic                c_i,
  input  logic                z_i,
  input  logic [PC_W-1:0]     target_i,
  input  logic                rel_i,
  input  logic [PC_W-1:0]     tos_pc_i,
  input  logic                tos_c_i,
  input  logic                tos_z_i,
  output shift_e              shift_o,
  output logic [WORD_W-1:0]   wr_word_o,
  output logic [PC_W-1:0]     pc_next_o,
  output logic                pc_load_o,
  output logic                c_o,
  output logic                z_o,
  output logic                flag_load_o
);

  localparam int unsigned PAD_W = WORD_W - PC_W - 2;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] call_tgt;

  assign pc_inc   = pc_i + PC_W'(1);
  assign call_tgt = rel_i ? (pc_i + target_i) : target_i;

  always_comb begin
    shift_o     = SH_HOLD;
    wr_word_o   = push_data_i;
    pc_next_o   = pc_inc;
    pc_load_o   = 1'b0;
    flag_load_o = 1'b0;
    unique case (op_i)
      OP_CALL: begin
        shift_o   = SH_DOWN;
        wr_word_o = {c_i, z_i, {PAD_W{1'b0}}, pc_inc};
        pc_next_o = call_tgt;
        pc_load_o = 1'b1;
      end
      OP_RET: begin
        shift_o     = SH_UP;
        pc_next_o   = tos_pc_i;
        pc_load_o   = 1'b1;
        flag_load_o = 1'b1;
      end
      OP_PUSH: shift_o = SH_DOWN;
      OP_POP:  shift_o = SH_UP;
      default: ;
    endcase
  end

  assign c_o = tos_c_i;
  assign z_o = tos_z_i;

endmodule

// File: rtl/cs_shift_stack.sv
module cs_shift_stack
  import call_stack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  shift_e            shift_i,
  input  logic [WORD_W-1:0] wr_word_i,
  output logic [WORD_W-1:0] tos_o
);

  logic [DEPTH-1:0][WORD_W-1:0] ent_q, ent_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WORD_W-1:0] down_v, up_v;
    if (i == 0) begin : g_top
      assign down_v = wr_word_i;
    end else begin : g_mid
      assign down_v = ent_q[i-1];
    end
    if (i == DEPTH - 1) begin : g_bot
      assign up_v = ent_q[i];  // bottom copies upward, keeps value
    end else begin : g_up
      assign up_v = ent_q[i+1];
    end
    assign ent_d[i] = (shift_i == SH_DOWN) ? down_v :
                      (shift_i == SH_UP)   ? up_v   : ent_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else         ent_q <= ent_d;
  end

  assign tos_o = ent_q[0];

endmodule

// File: rtl/call_stack_top.sv
module call_stack_top
  import call_stack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 20,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              rel_i,
  output logic [WORD_W-1:0] tos_o,
  output logic [PC_W-1:0]   pc_next_o,
  output logic              pc_load_o,
  output logic              c_o,
  output logic              z_o,
  output logic              flag_load_o
);

  localparam int unsigned C_BIT = WORD_W - 1;
  localparam int unsigned Z_BIT = WORD_W - 2;

  stk_op_e           op;
  shift_e            shift;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] tos;

  cs_op_arbiter u_arb (
    .call_i (call_i),
    .ret_i  (ret_i),
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  cs_flow_unit #(
    .WORD_W (WORD_W),
    .PC_W   (PC_W)
  ) u_flow (
    .op_i        (op),
    .push_data_i (push_data_i),
    .pc_i        (pc_i),
    .c_i         (c_i),
    .z_i         (z_i),
    .target_i    (target_i),
    .rel_i       (rel_i),
    .tos_pc_i    (tos[PC_W-1:0]),
    .tos_c_i     (tos[C_BIT]),
    .tos_z_i     (tos[Z_BIT]),
    .shift_o     (shift),
    .wr_word_o   (wr_word),
    .pc_next_o   (pc_next_o),
    .pc_load_o   (pc_load_o),
    .c_o         (c_o),
    .z_o         (z_o),
    .flag_load_o (flag_load_o)
  );

  cs_shift_stack #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .wr_word_i (wr_word),
    .tos_o     (tos)
  );

  assign tos_o = tos;

endmodule

// File: rtl/call_stack_chk.sv
module call_stack_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              call_i,
  input logic              ret_i,
  input logic [WORD_W-1:0] push_data_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              c_i,
  input logic              z_i,
  input logic [PC_W-1:0]   target_i,
  input logic              rel_i,
  input logic [WORD_W-1:0] tos_o,
  input logic [PC_W-1:0]   pc_next_o,
  input logic              pc_load_o,
  input logic              c_o,
  input logic              z_o,
  input logic              flag_load_o
);

  logic idle;
  assign idle = !(push_i || pop_i || call_i || ret_i);

  p_push_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !call_i && !ret_i |=> tos_o == $past(push_data_i));

  p_push_pop_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(push_i && !call_i && !ret_i) && pop_i && !push_i && !call_i && !ret_i
    |=> tos_o == $past(tos_o, 2));

  p_call_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> tos_o[WORD_W-1] == $past(c_i) && tos_o[WORD_W-2] == $past(z_i)
               && tos_o[WORD_W-3:PC_W] == '0
               && tos_o[PC_W-1:0] == PC_W'($past(pc_i) + PC_W'(1)));

  p_call_tgt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |-> pc_load_o && !flag_load_o
               && pc_next_o == (rel_i ? PC_W'(pc_i + target_i) : target_i));

  p_ret_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !call_i |-> pc_load_o && flag_load_o && pc_next_o == tos_o[PC_W-1:0]
                         && c_o == tos_o[WORD_W-1] && z_o == tos_o[WORD_W-2]);

  p_push_over_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !call_i && !ret_i |=> tos_o == $past(push_data_i));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(tos_o));

  p_idle_noload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !pc_load_o && !flag_load_o && pc_next_o == PC_W'(pc_i + PC_W'(1)));

endmodule

bind call_stack_top call_stack_chk #(
  .WORD_W (WORD_W),
  .PC_W   (PC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .push_data_i (push_data_i),
  .pc_i        (pc_i),
  .c_i         (c_i),
  .z_i         (z_i),
  .target_i    (target_i),
  .rel_i       (rel_i),
  .tos_o       (tos_o),
  .pc_next_o   (pc_next_o),
  .pc_load_o   (pc_load_o),
  .c_o         (c_o),
  .z_o         (z_o),
  .flag_load_o (flag_load_o)
);

// File: tb/call_stack_top_tb_top.sv
module call_stack_top_tb_top;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [19:0] pc_i = '0, target_i = '0;
  logic        c_i = 1'b0, z_i = 1'b0, rel_i = 1'b0;
  logic [31:0] tos_o;
  logic [19:0] pc_next_o;
  logic        pc_load_o, c_o, z_o, flag_load_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mdl[$];  // index 0 = top

  always #(CLK_P/2) clk_i = ~clk_i;

  call_stack_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .call_i(call_i), .ret_i(ret_i), .push_data_i(push_data_i), .pc_i(pc_i),
    .c_i(c_i), .z_i(z_i), .target_i(target_i), .rel_i(rel_i),
    .tos_o(tos_o), .pc_next_o(pc_next_o), .pc_load_o(pc_load_o),
    .c_o(c_o), .z_o(z_o), .flag_load_o(flag_load_o)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic mdl_reset();
    mdl.delete();
    for (int i = 0; i < 8; i++) mdl.push_back(32'h0);
  endtask

  task automatic mdl_push(input logic [31:0] w);
    mdl.push_front(w);
    void'(mdl.pop_back());
  endtask

  task automatic mdl_pop();
    mdl.push_back(mdl[7]);
    void'(mdl.pop_front());
  endtask

  task automatic step(input logic pu, po, ca, re, input logic [31:0] d,
                      input logic [19:0] pc, input logic c, z,
                      input logic [19:0] tg, input logic rl, input string tag);
    logic [19:0] e_pc;
    logic        e_ld, e_fl;
    @(negedge clk_i);
    push_i = pu; pop_i = po; call_i = ca; ret_i = re;
    push_data_i = d; pc_i = pc; c_i = c; z_i = z; target_i = tg; rel_i = rl;
    #1;
    e_pc = pc + 20'd1; e_ld = 1'b0; e_fl = 1'b0;
    if (ca) begin
      e_pc = rl ? pc + tg : tg; e_ld = 1'b1;
    end else if (re) begin
      e_pc = mdl[0][19:0]; e_ld = 1'b1; e_fl = 1'b1;
    end
    cmp(tag, "tos", tos_o, mdl[0]);
    cmp(tag, "pc_next", {12'h0, pc_next_o}, {12'h0, e_pc});
    cmp(tag, "loads", {30'h0, pc_load_o, flag_load_o}, {30'h0, e_ld, e_fl});
    if (re && !ca)
      cmp(tag, "flags", {30'h0, c_o, z_o}, {30'h0, mdl[0][31], mdl[0][30]});
    @(posedge clk_i);
    if (ca)       mdl_push({c, z, 10'b0, pc + 20'd1});
    else if (re)  mdl_pop();
    else if (pu)  mdl_push(d);
    else if (po)  mdl_pop();
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, 20'h12345, 0, 0, 20'h0, 0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    mdl_reset();
    #(CLK_P * 2 + 1);
    cmp("R1", "tos_in_reset", tos_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: popping an empty stack yields zero
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 32'h0, 20'h0, 0, 0, 20'h0, 0, "R1");
    // R2: nine pushes
    for (int i = 0; i < 9; i++)
      step(1, 0, 0, 0, 32'hA000_0000 + i, 20'h0, 0, 0, 20'h0, 0, "R2");
    idle("R10");
    // R3: eight pops bring back last eight words, oldest lost
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 32'h0, 20'h0, 0, 0, 20'h0, 0, "R3");
    // R4: bottom keeps replicating
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 32'h0, 20'h0, 0, 0, 20'h0, 0, "R4");
    idle("R4");
    // R5/R6: calls in both modes and with wrap
    step(0, 0, 1, 0, 32'h0, 20'h00100, 1, 0, 20'h00040, 1, "R6");
    step(0, 0, 1, 0, 32'h0, 20'hFFFF0, 0, 1, 20'h00020, 1, "R6");
    step(0, 0, 1, 0, 32'h0, 20'hFFFFF, 1, 1, 20'h54321, 0, "R6");
    idle("R5");
    // R7: returns restore pc and flags in reverse order
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 32'h0, 20'h777, 0, 0, 20'h0, 0, "R7");
    idle("R7");
    // R8: priority combinations
    step(1, 1, 1, 1, 32'hDEAD_BEEF, 20'h00AAA, 1, 0, 20'h00010, 1, "R8");
    step(1, 1, 0, 1, 32'hCAFE_F00D, 20'h00BBB, 0, 0, 20'h0, 0, "R8");
    step(1, 1, 0, 0, 32'h1234_5678, 20'h00CCC, 0, 0, 20'h0, 0, "R8");
    idle("R8");
    step(0, 1, 0, 1, 32'h0, 20'h00DDD, 0, 0, 20'h0, 0, "R8");
    // R9: idle cycles keep state
    for (int i = 0; i < 3; i++) idle("R9");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s = 4'($urandom);
      step(s[0], s[1], s[2] & s[3], s[3] & !s[2], $urandom, 20'($urandom),
           1'($urandom), 1'($urandom), 20'($urandom), 1'($urandom), "R10");
    end
    summary();
    $finish;
  end

endmodule